// File: doc/BRIEF.md
# Frame-Pulse Synchronous Serial Master

This block is a full-duplex serial master. Each word is announced by a pulse on a frame line, one serial clock period wide. The word is then shifted out on the data output while a word of the same length is shifted in from the data input. The word length is programmable from 4 to 16 bits, and the most significant bit goes first. The master drives its output on the rising serial clock edge and samples its input on the falling edge. The serial clock is low while nothing is being sent. Its period is an even multiple of the system clock, set by a half-period field.

On the parallel side, a transmit word is handed over with a valid/ready handshake. Every received word appears right-justified with a one-cycle valid strobe. When the next transmit word is already waiting as the last bit of a frame begins, its frame pulse overlaps that last bit period. The next frame then follows with no idle gap.

The control state machine has three states:
- **IDLE**: the serial lines are quiet and the block is ready for a word.
- **SYNC**: the frame pulse period runs.
- **SHIFT**: the data bits are exchanged.

Its transitions are:
- **IDLE to SYNC** when a word is accepted.
- **SYNC to SHIFT** at the rising edge that starts the first data bit.
- **SHIFT to SHIFT** (chained reload) when a pending word starts at the rising edge after the last bit.
- **SHIFT to IDLE** when that edge arrives with no word pending.

Top module: `fps_master`

## Requirements
- R1: A frame carries `cfg_size`+1 bits for field values 3 to 15, and field values 0 to 2 give 4 bits. Bits go out on `txd` with the most significant bit first, and bits of `tx_data` above the frame length are ignored.
- R2: Before each frame, `fss` is high for exactly one serial clock period. It rises at the same system clock edge as a rising edge of `sclk`.
- R3: `txd` changes only at rising edges of `sclk`, except when it returns low after a frame ends. `rxd` is sampled at the falling edges of `sclk`.
- R4: `rx_valid` is high for exactly one system clock cycle per frame. That cycle starts at the edge where `sclk` falls for the final bit.
- R5: `rx_data` holds the bits sampled from `rxd` during the same frame. They are right-justified, the first-sampled bit is the most significant, and unused upper bits are zero.
- R6: If `tx_valid` is high at the rising edge that starts a frame's last bit, the word is accepted there (`tx_ready` high). The next frame's pulse then overlaps that last bit period, so consecutive frame pulses start exactly N serial periods apart.
- R7: While idle, `sclk`, `fss` and `txd` are low and `tx_ready` is high, and after reset the block is idle.
- R8: The high time and the low time of `sclk` are each `cfg_half` system clock cycles, and a value of 0 acts as 1. The setting is captured when a transfer starts from idle.
- R9: `cfg_size` is captured when a word is accepted, and later changes do not alter that frame's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size | input | $clog2(MAX_BITS) | Frame length minus one |
| cfg_half | input | DIV_W | Serial clock half period in system clocks |
| tx_data | input | MAX_BITS | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word taken this cycle |
| rx_data | output | MAX_BITS | Received word, right-justified |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| sclk | output | 1 | Serial clock |
| fss | output | 1 | Frame pulse |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |

## Verification
The bench builds the block with MAX_BITS of 16 and DIV_W of 4. This makes every frame length from 4 to 16 bits and small half periods cheap enough to sweep. Every size field from 3 to 15 is combined with half periods of 1, 2 and 3 in chained bursts of three words. For each combination the bench computes, from arithmetic alone, the bit order, the pulse width, the clock high and low times and the spacing between frames. Separate single-frame runs cover the size clamp, the zero half period, a size change in mid-frame and the quiet lines between transfers.

// File: rtl/fps_pkg.sv
package fps_pkg;
    localparam int MIN_FRAME_BITS = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_SHIFT = 2'd2
    } fps_state_e;
endpackage

// File: rtl/fps_divider.sv
module fps_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == half - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/fps_rxshift.sv
module fps_rxshift #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             last,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word,
    output logic             valid
);
    logic [WIDTH-1:0] sh;
    logic [WIDTH-1:0] sh_next;

    assign sh_next = {sh[WIDTH-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (clear) begin
                sh <= '0;
            end else if (sample) begin
                sh <= sh_next;
                if (last) begin
                    word  <= sh_next;
                    valid <= 1'b1;
                end
            end
        end
    end

    // R4
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
endmodule

// File: rtl/fps_master.sv
module fps_master #(
    parameter int MAX_BITS = 16,
    parameter int DIV_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(MAX_BITS)-1:0] cfg_size,
    input  logic [DIV_W-1:0]            cfg_half,
    input  logic [MAX_BITS-1:0]         tx_data,
    input  logic                        tx_valid,
    output logic                        tx_ready,
    output logic [MAX_BITS-1:0]         rx_data,
    output logic                        rx_valid,
    output logic                        sclk,
    output logic                        fss,
    output logic                        txd,
    input  logic                        rxd
);
    import fps_pkg::*;

    localparam int              SIZE_W    = $clog2(MAX_BITS);
    localparam logic [SIZE_W-1:0] MIN_FIELD = SIZE_W'(MIN_FRAME_BITS - 1);
    localparam logic [DIV_W-1:0]  MIN_HALF  = DIV_W'(1);

    fps_state_e          state, state_nx;
    logic [SIZE_W-1:0]   idx;
    logic [SIZE_W-1:0]   size_q;
    logic [DIV_W-1:0]    half_q;
    logic [MAX_BITS-1:0] tx_q;
    logic                pend;
    logic                sclk_q, fss_q, txd_q;
    logic                tick, rise_tick, fall_tick;
    logic                accept;
    logic                rx_clear, rx_sample;

    function automatic logic [SIZE_W-1:0] clamp_size(input logic [SIZE_W-1:0] s);
        return (s < MIN_FIELD) ? MIN_FIELD : s;
    endfunction

    function automatic logic [DIV_W-1:0] clamp_half(input logic [DIV_W-1:0] h);
        return (h < MIN_HALF) ? MIN_HALF : h;
    endfunction

    fps_divider #(.DIV_W(DIV_W)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != ST_IDLE),
        .half  (half_q),
        .tick  (tick)
    );

    assign rise_tick = tick && !sclk_q;
    assign fall_tick = tick && sclk_q;

    assign tx_ready = (state == ST_IDLE) ||
                      (state == ST_SHIFT && rise_tick && idx == SIZE_W'(1));
    assign accept   = tx_valid && tx_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (tx_valid) state_nx = ST_SYNC;
            ST_SYNC:  if (rise_tick) state_nx = ST_SHIFT;
            ST_SHIFT: if (rise_tick && idx == '0 && !pend) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            size_q <= MIN_FIELD;
            half_q <= MIN_HALF;
            tx_q   <= '0;
            pend   <= 1'b0;
            sclk_q <= 1'b0;
            fss_q  <= 1'b0;
            txd_q  <= 1'b0;
        end else begin
            if (accept) begin
                tx_q   <= tx_data;
                size_q <= clamp_size(cfg_size);
                fss_q  <= 1'b1;
                if (state == ST_IDLE) begin
                    half_q <= clamp_half(cfg_half);
                    sclk_q <= 1'b1;
                end else begin
                    pend <= 1'b1;
                end
            end
            if (fall_tick) begin
                sclk_q <= 1'b0;
            end
            if (rise_tick) begin
                if (state == ST_SYNC) begin
                    sclk_q <= 1'b1;
                    fss_q  <= 1'b0;
                    txd_q  <= tx_q[size_q];
                    idx    <= size_q;
                end else if (state == ST_SHIFT) begin
                    if (idx != '0) begin
                        sclk_q <= 1'b1;
                        idx    <= idx - SIZE_W'(1);
                        txd_q  <= tx_q[idx - SIZE_W'(1)];
                    end else if (pend) begin
                        sclk_q <= 1'b1;
                        fss_q  <= 1'b0;
                        pend   <= 1'b0;
                        txd_q  <= tx_q[size_q];
                        idx    <= size_q;
                    end else begin
                        txd_q <= 1'b0;
                    end
                end
            end
        end
    end

    assign rx_clear  = rise_tick && (state == ST_SYNC ||
                       (state == ST_SHIFT && idx == '0 && pend));
    assign rx_sample = fall_tick && (state == ST_SHIFT);

    fps_rxshift #(.WIDTH(MAX_BITS)) rx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (rx_clear),
        .sample (rx_sample),
        .last   (idx == '0),
        .bit_in (rxd),
        .word   (rx_data),
        .valid  (rx_valid)
    );

    assign sclk = sclk_q;
    assign fss  = fss_q;
    assign txd  = txd_q;

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!sclk_q && !fss_q && !txd_q && tx_ready));

    // R2
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fss_q) |-> $rose(sclk_q));

    // R2
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fss_q) |-> $rose(sclk_q));

    // R3
    txd_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !$stable(txd_q)) |-> $rose(sclk_q));

    // R4
    rx_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $fell(sclk_q));
endmodule

// File: tb/fps_master_tb_top.sv
module fps_master_tb_top;
    localparam int MAX_BITS = 16;
    localparam int DIV_W    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [3:0]       cfg_size;
    logic [DIV_W-1:0] cfg_half;
    logic [15:0]      tx_data;
    logic             tx_valid;
    logic             tx_ready;
    logic [15:0]      rx_data;
    logic             rx_valid;
    logic             sclk, fss, txd;
    logic             rxd;

    fps_master #(.MAX_BITS(MAX_BITS), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_half(cfg_half),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .fss(fss),
        .txd(txd), .rxd(rxd)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sword(input int f);
        return 16'(f * 40503 + 12345) ^ 16'(f << 7);
    endfunction

    function automatic logic [15:0] lowmask(input int bits);
        return 16'((32'd1 << bits) - 1);
    endfunction

    int cur_bits = 4, cur_half = 1;
    int cyc = 0, last_rise = -1, last_fall = -1, fss_start = 0, n_fss = 0;
    int fss_t[0:255];
    logic [15:0] sent[0:255];
    int n_sent = 0;
    logic sclk_p = 0, fss_p = 0, txd_p = 0;
    int sl_frame = 0, sl_idx = 0, sl_cnt = 0;
    bit sl_active = 0, sl_armed = 0, last_frame_ok = 0;
    logic [15:0] sl_word = '0, sl_got = '0;

    // Slave model and monitor, sampling between clock edges
    always @(negedge clk) begin
        if (rst_n) begin
            bit rise, fall, final_now;
            rise = sclk && !sclk_p;
            fall = !sclk && sclk_p;
            final_now = 0;
            cyc++;
            if (rise) begin
                if (last_fall >= 0 && (sl_active || sl_armed))
                    chk(cyc - last_fall == cur_half, "R8 low time", cyc - last_fall, cur_half);
                last_rise = cyc;
                if (sl_armed) begin
                    sl_active = 1;
                    sl_idx = cur_bits - 1;
                    sl_word = sword(sl_frame);
                    sl_got = '0;
                    sl_cnt = 0;
                    rxd = sl_word[sl_idx];
                end else if (sl_active && sl_idx > 0) begin
                    sl_idx--;
                    rxd = sl_word[sl_idx];
                end
                sl_armed = fss;
            end
            if (fall) begin
                chk(cyc - last_rise == cur_half, "R8 high time", cyc - last_rise, cur_half);
                last_fall = cyc;
                if (sl_active) begin
                    sl_got = {sl_got[14:0], txd};
                    sl_cnt++;
                    if (sl_cnt == cur_bits) begin
                        final_now = 1;
                        chk(rx_valid == 1'b1, "R4 valid with final falling edge", int'(rx_valid), 1);
                        chk(rx_data == (sl_word & lowmask(cur_bits)), "R5 received word",
                            int'(rx_data), int'(sl_word & lowmask(cur_bits)));
                        chk(sl_got == (sent[sl_frame] & lowmask(cur_bits)), "R1 transmitted bits",
                            int'(sl_got), int'(sent[sl_frame] & lowmask(cur_bits)));
                        last_frame_ok = (rx_data == (sl_word & lowmask(cur_bits))) &&
                                        (sl_got == (sent[sl_frame] & lowmask(cur_bits)));
                        sl_frame++;
                        sl_active = 0;
                    end
                end
            end
            if (rx_valid && !final_now)
                chk(0, "R4 stray valid", 1, 0);
            if (fss && !fss_p) begin
                chk(rise, "R2 pulse starts with rising clock", int'(rise), 1);
                fss_start = cyc;
                fss_t[n_fss] = cyc;
                n_fss++;
            end
            if (!fss && fss_p)
                chk(cyc - fss_start == 2 * cur_half, "R2 pulse width", cyc - fss_start, 2 * cur_half);
            if (txd !== txd_p && !rise)
                chk(txd == 1'b0 && !sl_active, "R3 txd moved off a rising edge", int'(txd), 0);
            sclk_p = sclk;
            fss_p = fss;
            txd_p = txd;
        end
    end

    task automatic wait_done(input int hq);
        while (sl_frame < n_sent) @(negedge clk);
        repeat (2 * hq + 2) @(negedge clk);
    endtask

    task automatic idle_check(input string tag);
        int busy = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (sclk || fss || txd || !tx_ready) busy++;
        end
        chk(busy == 0, tag, busy, 0);
    endtask

    task automatic burst(input int field, input int hfield, input int bits, input int hq,
                         input int n, input bit chained);
        int base;
        cfg_size = 4'(field);
        cfg_half = DIV_W'(hfield);
        cur_bits = bits;
        cur_half = hq;
        base = n_fss;
        for (int k = 0; k < n; k++) begin
            logic [15:0] w;
            w = (k == 0) ? (16'hFFFF ^ 16'(field)) :
                (k == 1) ? (16'hA5C3 ^ 16'(hq << 4)) : 16'(k * 7919 + field * 263 + hq);
            sent[n_sent] = w;
            n_sent++;
            tx_data = w;
            tx_valid = 1'b1;
            while (!tx_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            if (!chained) begin
                tx_valid = 1'b0;
                wait_done(hq);
            end
        end
        tx_valid = 1'b0;
        wait_done(hq);
        if (chained)
            for (int k = 1; k < n; k++)
                chk(fss_t[base + k] - fss_t[base + k - 1] == bits * 2 * hq, "R6 back-to-back spacing",
                    fss_t[base + k] - fss_t[base + k - 1], bits * 2 * hq);
        idle_check("R7 quiet after transfer");
    endtask

    initial begin
        cfg_size = 4'd7;
        cfg_half = DIV_W'(1);
        tx_data = '0;
        tx_valid = 1'b0;
        rxd = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk(!sclk && !fss && !txd, "R7 lines low after reset", int'({sclk, fss, txd}), 0);
        chk(tx_ready && !rx_valid, "R7 ready after reset", int'({tx_ready, rx_valid}), 2);

        // Sweep every size field with several half periods, chained (R1 R2 R5 R6 R8)
        for (int b = 3; b <= 15; b++)
            for (int h = 1; h <= 3; h++)
                burst(b, h, b + 1, h, 3, 1'b1);

        // Size clamp: field 1 gives 4 bits; half 0 acts as 1 (R1, R8)
        burst(1, 0, 4, 1, 2, 1'b0);
        chk(last_frame_ok, "R1 clamped size frame", int'(last_frame_ok), 1);
        burst(0, 2, 4, 2, 1, 1'b0);

        // Size change after acceptance does not alter the frame (R9)
        cfg_size = 4'd7;
        cfg_half = DIV_W'(2);
        cur_bits = 8;
        cur_half = 2;
        sent[n_sent] = 16'h3C96;
        n_sent++;
        tx_data = 16'h3C96;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        cfg_size = 4'd11;
        last_frame_ok = 0;
        wait_done(2);
        chk(last_frame_ok, "R9 size held for the running frame", int'(last_frame_ok), 1);
        idle_check("R9 no extra bits after the frame");

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", sl_frame, n_sent);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule